// File: doc/BRIEF.md
# Bilinear Chroma Subpixel Interpolator

This block builds a chroma prediction block from a window of reference samples at eighth-sample precision. Reference rows carry the two chroma planes interleaved byte by byte (blue-difference, red-difference, blue-difference, ...). A caller pulses a start strobe with a horizontal fraction, a vertical fraction (each 0 to 7), a width code and a height code. It then streams reference rows in, one full row per beat, and collects predicted rows, one full interleaved row per beat. Both streams use valid/ready handshakes.

Every output byte is a four-tap weighted blend of one reference sample, the sample of the same plane to its right (two bytes further along), the sample directly below, and the diagonal one. The sum is rounded, scaled down by 64 and clipped to a byte. The block keeps the previous reference row, so each row after the first feeds two consecutive output rows. A block of H output rows therefore consumes H+1 reference rows.

Top module: `chroma_bilerp_interp`

## Requirements
- R1: With fractions fx (horizontal) and fy (vertical), the tap weights are (8-fx)(8-fy) for the sample, fx(8-fy) for its right neighbour, (8-fx)fy for the sample below and fx·fy for the diagonal sample. The four always add up to 64.
- R2: Each output byte is the weighted sum plus 32, shifted right by 6 and clipped to 0..255. This includes the all-255 input case, which gives 255.
- R3: Byte k of a row is 8 bits wide, with byte 0 in the least significant bits. The right neighbour of byte j is byte j+2 of the same row, so the two interleaved planes never mix.
- R4: Output row r uses reference rows r (upper) and r+1 (lower). Exactly H+1 rows are accepted per block, and `row_ready_o` stays low once they have been taken and whenever the block is idle.
- R5: Width code `wsel_i` selects 0→2, 1→4, 2→8 samples per plane, which is 4, 8 or 16 output bytes. Output bytes at and above that count are 0. An input row always has 18 bytes, and bytes beyond the width plus 2 are ignored.
- R6: Height code `hsel_i` selects 0→2, 1→4, 2→8 rows. Exactly that many output rows are emitted, in top-to-bottom order.
- R7: Fractions, codes and weights are latched at an accepted start and held for the whole block. A start during a block is ignored: its parameters change no output and raise no error.
- R8: `done_o` is a one-cycle pulse in the cycle right after the last output row is accepted.
- R9: With fx = fy = 0, each output byte equals the upper reference byte at the same position.
- R10: While `pred_valid_o` is high and `pred_ready_i` is low, the output row is held unchanged. Stalls on either side lose no row and no held upper row.
- R11: Code 3 for width or height sets `err_o` at the start, and no row is requested or produced. `err_o` stays set until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| frac_x_i | input | 3 | Horizontal eighth-sample fraction |
| frac_y_i | input | 3 | Vertical eighth-sample fraction |
| wsel_i | input | 2 | Width code |
| hsel_i | input | 2 | Height code |
| row_valid_i | input | 1 | Reference row valid |
| row_ready_o | output | 1 | Reference row accepted when high with valid |
| row_data_i | input | 144 | Reference row, 18 interleaved bytes |
| pred_valid_o | output | 1 | Predicted row valid |
| pred_ready_i | input | 1 | Sink accepts predicted row |
| pred_data_o | output | 128 | Predicted row, 16 interleaved bytes |
| done_o | output | 1 | Block finished pulse |
| err_o | output | 1 | Unsupported width or height code |

## Verification
The bench builds the block with its default limits: 8 samples per plane and 8 rows. At these limits all three width codes and all three height codes are legal, and code 3 serves as the illegal value for both. The full 18-byte input row is exercised, which reaches the two guard bytes at the right edge and the zeroed output bytes of narrow blocks. The 64 fraction pairs are each run with a random width, random height, random data and random stalls on both sides. Directed cases cover the exact copy at zero fraction, saturated input, an intruding start and the illegal codes.

// File: rtl/chroma_interp_pkg.sv
package chroma_interp_pkg;

  localparam int SAMP_W = 8;
  localparam int WT_W   = 7;
  localparam int ACC_W  = 16;

  typedef struct packed {
    logic [WT_W-1:0] here;
    logic [WT_W-1:0] right;
    logic [WT_W-1:0] below;
    logic [WT_W-1:0] diag;
  } tap_wts_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRIME = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  // Bilinear weights from the two eighth-sample fractions.
  function automatic tap_wts_t derive_wts(input logic [2:0] fx, input logic [2:0] fy);
    tap_wts_t   w;
    logic [7:0] cx, cy, px, py, t;
    cx = 8'd8 - {5'd0, fx};
    cy = 8'd8 - {5'd0, fy};
    px = {5'd0, fx};
    py = {5'd0, fy};
    t = cx * cy; w.here  = t[WT_W-1:0];
    t = px * cy; w.right = t[WT_W-1:0];
    t = cx * py; w.below = t[WT_W-1:0];
    t = px * py; w.diag  = t[WT_W-1:0];
    return w;
  endfunction

  // Four-tap blend with round-half-up, divide by 64 and byte clip.
  function automatic logic [SAMP_W-1:0] blend4(input tap_wts_t w,
                                               input logic [SAMP_W-1:0] a,
                                               input logic [SAMP_W-1:0] b,
                                               input logic [SAMP_W-1:0] c,
                                               input logic [SAMP_W-1:0] d);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] scaled;
    acc = ACC_W'(w.here)  * ACC_W'(a)
        + ACC_W'(w.right) * ACC_W'(b)
        + ACC_W'(w.below) * ACC_W'(c)
        + ACC_W'(w.diag)  * ACC_W'(d);
    acc    = acc + ACC_W'(32);
    scaled = acc >> 6;
    return (scaled > ACC_W'(255)) ? 8'hFF : scaled[SAMP_W-1:0];
  endfunction

  // A size code is legal when it selects at most the configured maximum.
  function automatic logic code_ok(input logic [1:0] sel, input int unsigned n_codes);
    return (32'(sel) < n_codes);
  endfunction

endpackage

// File: rtl/chroma_weight_reg.sv
module chroma_weight_reg
  import chroma_interp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] fx,
  input  logic [2:0] fy,
  output tap_wts_t   wts
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wts <= '0;
    end else if (load) begin
      wts <= derive_wts(fx, fy);
    end
  end

endmodule

// File: rtl/chroma_row_filter.sv
module chroma_row_filter
  import chroma_interp_pkg::*;
#(
  parameter int MAX_W = 8
) (
  input  tap_wts_t                          wts,
  input  logic [(2*MAX_W+2)*SAMP_W-1:0]     upper,
  input  logic [(2*MAX_W+2)*SAMP_W-1:0]     lower,
  input  logic [$clog2(2*MAX_W+1)-1:0]      act_bytes,
  output logic [2*MAX_W*SAMP_W-1:0]         pred
);

  localparam int OUT_BYTES = 2 * MAX_W;
  localparam int ABW       = $clog2(OUT_BYTES + 1);
  localparam int PLANE_GAP = 2;

  for (genvar j = 0; j < OUT_BYTES; j++) begin : g_byte
    localparam logic [ABW-1:0] POS = ABW'(j);
    logic [SAMP_W-1:0] mixed;
    assign mixed = blend4(wts,
                          upper[SAMP_W*j +: SAMP_W],
                          upper[SAMP_W*(j+PLANE_GAP) +: SAMP_W],
                          lower[SAMP_W*j +: SAMP_W],
                          lower[SAMP_W*(j+PLANE_GAP) +: SAMP_W]);
    assign pred[SAMP_W*j +: SAMP_W] = (POS < act_bytes) ? mixed : '0;
  end

endmodule

// File: rtl/chroma_stream_ctrl.sv
module chroma_stream_ctrl
  import chroma_interp_pkg::*;
#(
  parameter int MAX_W = 8,
  parameter int MAX_H = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic [1:0] wsel_i,
  input  logic [1:0] hsel_i,
  input  logic row_valid_i,
  input  logic pred_ready_i,
  output logic row_ready_o,
  output logic pred_valid_o,
  output logic accept_start,
  output logic in_fire,
  output logic out_fire,
  output logic issue,
  output logic busy,
  output logic done_o,
  output logic err_o
);

  localparam int W_CODES = $clog2(MAX_W);
  localparam int H_CODES = $clog2(MAX_H);
  localparam int HCW     = $clog2(MAX_H + 1);

  phase_t          phase;
  logic [HCW-1:0]  rows_left;
  logic            pv_q;
  logic            codes_ok;
  logic            reject_start;

  assign codes_ok     = code_ok(wsel_i, W_CODES) && code_ok(hsel_i, H_CODES);
  assign accept_start = start_i && (phase == PH_IDLE) && codes_ok;
  assign reject_start = start_i && (phase == PH_IDLE) && !codes_ok;

  assign row_ready_o  = (phase == PH_PRIME) ||
                        ((phase == PH_RUN) && (rows_left != '0) && (!pv_q || pred_ready_i));
  assign in_fire      = row_valid_i && row_ready_o;
  assign out_fire     = pv_q && pred_ready_i;
  assign issue        = in_fire && (phase == PH_RUN);
  assign busy         = (phase != PH_IDLE);
  assign pred_valid_o = pv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      rows_left <= '0;
      pv_q      <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept_start) begin
            phase     <= PH_PRIME;
            rows_left <= HCW'(2) << hsel_i;
            err_o     <= 1'b0;
          end else if (reject_start) begin
            err_o <= 1'b1;
          end
        end
        PH_PRIME: begin
          if (in_fire) phase <= PH_RUN;
        end
        PH_RUN: begin
          if (issue) begin
            rows_left <= rows_left - HCW'(1);
            pv_q      <= 1'b1;
          end else if (out_fire) begin
            pv_q <= 1'b0;
            if (rows_left == '0) begin
              phase  <= PH_IDLE;
              done_o <= 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/chroma_bilerp_interp.sv
module chroma_bilerp_interp
  import chroma_interp_pkg::*;
#(
  parameter int MAX_W = 8,
  parameter int MAX_H = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_i,
  input  logic [2:0]                      frac_x_i,
  input  logic [2:0]                      frac_y_i,
  input  logic [1:0]                      wsel_i,
  input  logic [1:0]                      hsel_i,
  input  logic                            row_valid_i,
  output logic                            row_ready_o,
  input  logic [(2*MAX_W+2)*8-1:0]        row_data_i,
  output logic                            pred_valid_o,
  input  logic                            pred_ready_i,
  output logic [2*MAX_W*8-1:0]            pred_data_o,
  output logic                            done_o,
  output logic                            err_o
);

  localparam int IN_BITS  = (2 * MAX_W + 2) * SAMP_W;
  localparam int OUT_BITS = 2 * MAX_W * SAMP_W;
  localparam int ABW      = $clog2(2 * MAX_W + 1);

  // Named internal events, visible to the bound checker.
  logic accept_start;
  logic in_fire;
  logic out_fire;
  logic issue;
  logic busy;

  tap_wts_t              wts;
  logic [IN_BITS-1:0]    upper_row;
  logic [ABW-1:0]        act_bytes;
  logic [OUT_BITS-1:0]   filtered;
  logic [OUT_BITS-1:0]   pred_q;

  chroma_stream_ctrl #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .wsel_i       (wsel_i),
    .hsel_i       (hsel_i),
    .row_valid_i  (row_valid_i),
    .pred_ready_i (pred_ready_i),
    .row_ready_o  (row_ready_o),
    .pred_valid_o (pred_valid_o),
    .accept_start (accept_start),
    .in_fire      (in_fire),
    .out_fire     (out_fire),
    .issue        (issue),
    .busy         (busy),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  chroma_weight_reg u_wts (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept_start),
    .fx    (frac_x_i),
    .fy    (frac_y_i),
    .wts   (wts)
  );

  chroma_row_filter #(.MAX_W(MAX_W)) u_filt (
    .wts       (wts),
    .upper     (upper_row),
    .lower     (row_data_i),
    .act_bytes (act_bytes),
    .pred      (filtered)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_row <= '0;
      act_bytes <= '0;
      pred_q    <= '0;
    end else begin
      if (accept_start) act_bytes <= ABW'(4) << wsel_i;
      if (in_fire)      upper_row <= row_data_i;
      if (issue)        pred_q    <= filtered;
    end
  end

  assign pred_data_o = pred_q;

endmodule

// File: rtl/chroma_bilerp_chk.sv
module chroma_bilerp_chk
  import chroma_interp_pkg::*;
#(
  parameter int OUT_BITS = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                out_fire,
  input logic                row_ready_o,
  input logic                pred_valid_o,
  input logic                pred_ready_i,
  input logic [OUT_BITS-1:0] pred_data_o,
  input logic                done_o,
  input logic                err_o,
  input tap_wts_t            wts
);

  logic [8:0] wsum;
  assign wsum = 9'(wts.here) + 9'(wts.right) + 9'(wts.below) + 9'(wts.diag);

  assert_wsum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (wsum == 9'd64));

  assert_wts_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wts));

  assert_pred_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid_o && !pred_ready_i) |=> (pred_valid_o && $stable(pred_data_o)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(out_fire));

  assert_err_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!pred_valid_o && !row_ready_o));

  assert_idle_no_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !row_ready_o);

endmodule

bind chroma_bilerp_interp chroma_bilerp_chk #(.OUT_BITS(2*MAX_W*8)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .out_fire     (out_fire),
  .row_ready_o  (row_ready_o),
  .pred_valid_o (pred_valid_o),
  .pred_ready_i (pred_ready_i),
  .pred_data_o  (pred_data_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .wts          (wts)
);

// File: tb/chroma_bilerp_interp_test.sv
`timescale 1ns/1ps
module chroma_bilerp_interp_test;

  localparam int MAX_W    = 8;
  localparam int MAX_H    = 8;
  localparam int IN_B     = 2 * MAX_W + 2;
  localparam int OUT_B    = 2 * MAX_W;
  localparam int IN_BITS  = IN_B * 8;
  localparam int OUT_BITS = OUT_B * 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start_i = 1'b0;
  logic [2:0]          frac_x_i = '0;
  logic [2:0]          frac_y_i = '0;
  logic [1:0]          wsel_i = '0;
  logic [1:0]          hsel_i = '0;
  logic                row_valid_i = 1'b0;
  logic                row_ready_o;
  logic [IN_BITS-1:0]  row_data_i = '0;
  logic                pred_valid_o;
  logic                pred_ready_i = 1'b0;
  logic [OUT_BITS-1:0] pred_data_o;
  logic                done_o;
  logic                err_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic [IN_BITS-1:0] refrows [0:MAX_H];

  always #2.5 clk = ~clk;

  chroma_bilerp_interp #(.MAX_W(MAX_W), .MAX_H(MAX_H)) uut (.*);

  task automatic check(input logic ok, input string tag,
                       input logic [OUT_BITS-1:0] act, input logic [OUT_BITS-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected byte: weights R1, rounding and clip R2, written via division.
  function automatic int model_byte(int fx, int fy, int a, int b, int c, int d);
    int s, r;
    s = (8 - fx) * (8 - fy) * a + fx * (8 - fy) * b + (8 - fx) * fy * c + fx * fy * d;
    r = (s + 32) / 64;
    return (r > 255) ? 255 : r;
  endfunction

  // Expected row: neighbour two bytes on (R3), upper row r, lower r+1 (R4), zero beyond width (R5).
  function automatic logic [OUT_BITS-1:0] model_row(int fx, int fy, int nbytes,
                                                     logic [IN_BITS-1:0] up, logic [IN_BITS-1:0] dn);
    logic [OUT_BITS-1:0] row;
    row = '0;
    for (int j = 0; j < OUT_B; j++) begin
      if (j < nbytes)
        row[8*j +: 8] = 8'(model_byte(fx, fy, int'(up[8*j +: 8]), int'(up[8*(j+2) +: 8]),
                                      int'(dn[8*j +: 8]), int'(dn[8*(j+2) +: 8])));
    end
    return row;
  endfunction

  task automatic run_block(input int fx, input int fy, input int ws, input int hs,
                           input int pattern, input bit intrude);
    int  nbytes, h, nin, nout, it;
    bit  finished, last_fire, ready_checked, prev_stall;
    logic [OUT_BITS-1:0] prev_data, exp;
    string tag;
    nbytes = 4 << ws;
    h      = 2 << hs;
    for (int r = 0; r <= MAX_H; r++)
      for (int k = 0; k < IN_B; k++)
        refrows[r][8*k +: 8] = (pattern == 1) ? 8'hFF : 8'($urandom);
    @(negedge clk);
    start_i = 1'b1; frac_x_i = 3'(fx); frac_y_i = 3'(fy);
    wsel_i = 2'(ws); hsel_i = 2'(hs);
    @(negedge clk);
    start_i = 1'b0;
    // Scramble parameters: latched values must rule the block (R7).
    frac_x_i = 3'($urandom); frac_y_i = 3'($urandom);
    wsel_i = 2'($urandom % 3); hsel_i = 2'($urandom % 3);
    check(err_o == 1'b0, "R11 err cleared by accepted start", OUT_BITS'(err_o), '0);
    nin = 0; nout = 0; it = 0;
    finished = 0; last_fire = 0; ready_checked = 0; prev_stall = 0; prev_data = '0;
    while (!finished && it < 600) begin
      @(negedge clk);
      it++;
      if (prev_stall)
        check(pred_valid_o && pred_data_o == prev_data, "R10 held under stall", pred_data_o, prev_data);
      if (done_o) begin
        check(last_fire, "R8 done timing", OUT_BITS'(done_o), OUT_BITS'(last_fire));
        check(nout == h, "R6 row count", OUT_BITS'(nout), OUT_BITS'(h));
        check(nin == h + 1, "R4 rows consumed", OUT_BITS'(nin), OUT_BITS'(h + 1));
        check(err_o == 1'b0, "R7 intruding start ignored", OUT_BITS'(err_o), '0);
        finished = 1;
      end else if (last_fire) begin
        check(1'b0, "R8 done missing", '0, OUT_BITS'(1));
      end
      last_fire = 0;
      if (!finished) begin
        if (intrude && it == 4) begin
          start_i = 1'b1; wsel_i = 2'd3; frac_x_i = 3'(fx ^ 5);
        end else begin
          start_i = 1'b0;
        end
        row_valid_i  = (nin <= h) && ($urandom % 4 != 0);
        row_data_i   = (nin <= h) ? refrows[nin] : IN_BITS'($urandom);
        pred_ready_i = ($urandom % 3 != 0);
        #1;
        if (nin > h && !ready_checked) begin
          check(row_ready_o == 1'b0, "R4 no extra row requested", OUT_BITS'(row_ready_o), '0);
          ready_checked = 1;
        end
        if (row_valid_i && row_ready_o) nin++;
        prev_stall = pred_valid_o && !pred_ready_i;
        prev_data  = pred_data_o;
        if (pred_valid_o && pred_ready_i) begin
          exp = model_row(fx, fy, nbytes, refrows[nout], refrows[nout + 1]);
          if (fx == 0 && fy == 0) begin
            tag = "R9 identity";
            exp = '0;
            for (int j = 0; j < nbytes; j++) exp[8*j +: 8] = refrows[nout][8*j +: 8];
          end else if (pattern == 1) tag = "R2 saturated";
          else tag = "R1 R3 R5 blended row";
          check(pred_data_o == exp, tag, pred_data_o, exp);
          nout++;
          if (nout == h) last_fire = 1;
        end
      end
    end
    if (!finished) check(1'b0, "R6 block never finished", '0, OUT_BITS'(1));
    start_i = 1'b0; row_valid_i = 1'b0; pred_ready_i = 1'b0;
  endtask

  task automatic bad_start(input int ws, input int hs);
    @(negedge clk);
    start_i = 1'b1; wsel_i = 2'(ws); hsel_i = 2'(hs);
    row_valid_i = 1'b1; pred_ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 4; c++) begin
      check(err_o && !row_ready_o && !pred_valid_o, "R11 illegal code",
            OUT_BITS'({err_o, row_ready_o, pred_valid_o}), OUT_BITS'(3'b100));
      @(negedge clk);
    end
    row_valid_i = 1'b0; pred_ready_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pred_valid_o && !row_ready_o && !done_o && !err_o, "R4 reset state",
          OUT_BITS'({pred_valid_o, row_ready_o, done_o, err_o}), '0);
    // Directed corners.
    run_block(0, 0, 2, 2, 0, 0);
    run_block(7, 7, 2, 2, 1, 0);
    run_block(3, 5, 0, 0, 0, 1);
    bad_start(3, 0);
    bad_start(1, 3);
    run_block(4, 4, 1, 1, 0, 0);
    // Every fraction pair with random geometry and stalls.
    for (int d = 0; d < 64; d++)
      run_block(d % 8, d / 8, int'($urandom % 3), int'($urandom % 3), 0, (d % 9) == 4);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule